// File: doc/BRIEF.md
# Repeating Serial Code Burst Sender

This block turns a fixed 16-bit identification code into a short serial burst on one wire. It is meant for a one-button alert: the code is wired in parallel at the code input, and a single level-sensitive activate input starts the burst. While activate is held high, the code is shifted out one bit per clock, least significant bit first. Each 16-clock send frame is followed by a 16-clock silent frame. After a fixed number of sends the block locks itself off.

A 4-bit position counter addresses a 16-to-1 selector whose raw output is active low. That output is inverted so the line carries the true bit value. A second counter advances each time the position counter wraps. Its lowest bit tells a send frame from a silent one, and a decode of its upper bits ends the burst. A static select input chooses three sends or four. After the last send a done flag stays raised until activate is released. Releasing activate is the only way to re-arm the block.

Top module: `code_burst_tx`

## Requirements
- R1: While reset is asserted, or while the synchronized activate is low, ser_o, tx_active_o and done_o are all 0.
- R2: activate_i passes through two flops. The first send frame begins in the cycle that follows the second rising clock edge at which activate_i is sampled high.
- R3: In the k-th cycle of a send frame (k = 0..15), ser_o equals code_i[k]. Bit 0 goes first and the bit is not inverted.
- R4: Frames last 16 cycles each. Even-numbered frames (frame counter bit 0 = 0) are send frames with tx_active_o = 1. Odd-numbered frames are silent, with tx_active_o = 0 and ser_o = 0.
- R5: With rep4_sel_i = 0, exactly three send frames occur. done_o rises 96 cycles after the first send cycle, when the frame count reaches 6 (bits 1 and 2 set).
- R6: With rep4_sel_i = 1, exactly four send frames occur. done_o rises 128 cycles after the first send cycle, when the frame count reaches 8 (bit 3 set).
- R7: Once done_o is high and activate stays high, done_o stays high, tx_active_o stays 0 and ser_o stays 0.
- R8: Dropping activate clears done_o and both counters. A later activation restarts from frame 0, bit 0, including after a burst that was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Level-sensitive burst request, asynchronous to clk_i |
| rep4_sel_i | input | 1 | Static repeat select: 0 gives three sends, 1 gives four |
| code_i | input | 16 | Parallel code to send, bit 0 first |
| ser_o | output | 1 | Serial data line, true polarity, 0 when not sending |
| tx_active_o | output | 1 | High during send frames |
| done_o | output | 1 | High once the burst has completed, until activate drops |

## Verification
The assertions assume that code_i and rep4_sel_i stay constant while a burst is in progress. They also assume activate_i is low at the moment reset is released, so the synchronizer's two-cycle delay lines up with the port. The stimulus changes the code and the repeat select only while activate is low and the synchronizer has drained. It drives activate only on falling clock edges and holds it low throughout reset. Walking-one codes and several dense patterns are run under both repeat settings, so that every bit position is checked in every send frame.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Repeat select encoding on rep4_sel_i
    typedef enum logic {
        REP_THREE = 1'b0,
        REP_FOUR  = 1'b1
    } rep_mode_e;

    // Frame counter width: must reach the larger stop count (8)
    localparam int unsigned FRM_W = 4;

endpackage

// File: rtl/cbt_sync.sv
module cbt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/cbt_sel.sv
module cbt_sel #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic             pick_no   // active-low selected bit
);
    logic [WIDTH-1:0] hot;

    for (genvar g = 0; g < WIDTH; g++) begin : g_dec
        assign hot[g] = (idx_i == SEL_W'(g));
    end

    assign pick_no = ~|(data_i & hot);
endmodule

// File: rtl/cbt_stop.sv
module cbt_stop
    import cbt_pkg::*;
(
    input  logic [FRM_W-1:0] frm_i,
    input  rep_mode_e        mode_i,
    output logic             stop_o
);
    always_comb begin
        unique case (mode_i)
            REP_THREE: stop_o = frm_i[2] & frm_i[1];  // count 6
            REP_FOUR:  stop_o = frm_i[3];             // count 8
            default:   stop_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/code_burst_tx.sv
module code_burst_tx
    import cbt_pkg::*;
#(
    parameter int unsigned CODE_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SEL_W      = $clog2(CODE_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              activate_i,
    input  logic              rep4_sel_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ser_o,
    output logic              tx_active_o,
    output logic              done_o
);
    localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(CODE_W - 1);

    typedef struct packed {
        logic [SEL_W-1:0] pos;
        logic [FRM_W-1:0] frm;
    } state_t;

    state_t    st_d, st_q;
    logic      act_sync;
    logic      stop;
    logic      pick_n;
    rep_mode_e mode;

    assign mode = rep_mode_e'(rep4_sel_i);

    cbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (activate_i),
        .sync_o  (act_sync)
    );

    cbt_stop u_stop (
        .frm_i  (st_q.frm),
        .mode_i (mode),
        .stop_o (stop)
    );

    cbt_sel #(.WIDTH(CODE_W)) u_sel (
        .data_i  (code_i),
        .idx_i   (st_q.pos),
        .pick_no (pick_n)
    );

    always_comb begin
        st_d = st_q;
        if (!act_sync) begin
            st_d.pos = '0;
            st_d.frm = '0;
        end else if (stop) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.pos == LAST_POS) st_d.frm = st_q.frm + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tx_active_o = act_sync & ~stop & ~st_q.frm[0];
    assign ser_o       = tx_active_o & ~pick_n;
    assign done_o      = act_sync & stop;
endmodule

// File: rtl/cbt_chk.sv
module cbt_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic activate_i,
    input logic act_sync,
    input logic ser_o,
    input logic tx_active_o,
    input logic done_o
);
    // R2
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(act_sync) |-> ($past(activate_i) && $past(activate_i, 2)));

    // R4
    gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_active_o |-> !ser_o);

    // R7
    locked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !tx_active_o);

    // R7
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && act_sync) |=> (done_o || !act_sync));

    // R1
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(act_sync) |-> (!done_o && !tx_active_o));
endmodule

bind code_burst_tx cbt_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .activate_i  (activate_i),
    .act_sync    (act_sync),
    .ser_o       (ser_o),
    .tx_active_o (tx_active_o),
    .done_o      (done_o)
);

// File: tb/sim_code_burst_tx.sv
module sim_code_burst_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act = 1'b0;
    logic        rep4 = 1'b0;
    logic [15:0] code = '0;
    logic        ser, txa, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    code_burst_tx u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .activate_i  (act),
        .rep4_sel_i  (rep4),
        .code_i      (code),
        .ser_o       (ser),
        .tx_active_o (txa),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actv, expv, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(ser == 1'b0,  req, ser,  0);
        chk(txa == 1'b0,  req, txa,  0);
        chk(done == 1'b0, req, done, 0);
    endtask

    function automatic logic [15:0] pick_code(input int i);
        if (i < 16) return 16'(1) << i;
        case (i)
            16: return 16'h0000;
            17: return 16'hFFFF;
            18: return 16'hA5C3;
            default: return 16'h3C5A;
        endcase
    endfunction

    // Run one activation; stop_after < 0 runs to completion plus a tail.
    task automatic run_burst(input logic [15:0] c, input bit r4, input int stop_after);
        int stop_frm;
        int last_n;
        code = c;
        rep4 = r4;
        stop_frm = r4 ? 8 : 6;
        last_n = (stop_after < 0) ? stop_frm * 16 + 24 : stop_after;
        repeat (4) @(negedge clk);
        chk_idle("R1");
        act = 1'b1;
        @(negedge clk);
        chk(txa == 1'b0, "R2", txa, 0);
        for (int n = 0; n <= last_n; n++) begin
            int  frm;
            bit  ex_tx, ex_done, ex_ser;
            @(negedge clk);
            frm     = n / 16;
            ex_done = (frm >= stop_frm);
            ex_tx   = !ex_done && (frm % 2 == 0);
            ex_ser  = ex_tx && c[n % 16];
            chk(txa == ex_tx, "R4", txa, ex_tx);
            chk(ser == ex_ser, "R3", ser, ex_ser);
            chk(done == ex_done, r4 ? "R6" : "R5", done, ex_done);
            if (n > stop_frm * 16) chk(!txa && done, "R7", txa, 0);
        end
        act = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_idle("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 20; i++) begin
                run_burst(pick_code(i), bit'(r), -1);
            end
            // R8: cut a burst short mid-send, then re-arm and run in full
            run_burst(16'hC0DE, bit'(r), 40);
            run_burst(16'h1234, bit'(r), -1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule